// File: doc/BRIEF.md
# Eight-Bit Event Timer with Steerable Prescaler

This block is an 8-bit up-counter. It counts either a qualified instruction-cycle enable or one chosen edge of an external pin. A single ripple prescaler sits between the count source and the counter. One configuration bit hands that prescaler either to the timer, or to a watchdog path as a postscaler on the watchdog tick; it is never given to both. When the counter wraps from FFh to 00h it emits a one-cycle overflow pulse and sets a sticky overflow flag that only an explicit clear removes.

All configuration lives in one 8-bit option register, and every bit of it resets to 1. The register also holds two bits that this block only stores and drives out: a pull-up disable and an interrupt-edge select. Software may load the counter directly at any time, and doing so empties the prescaler.

Top module: `event_timer8`

## Requirements
- R1: After reset the option register reads FFh, the counter reads 00h, the overflow flag, overflow pulse and watchdog event are 0, and the pull-up disable and interrupt-rising outputs are 1.
- R2: A write to the option register stores all eight bits, which are read back unchanged until the next write. Bit 7 drives the pull-up disable output and bit 6 drives the interrupt-rising output.
- R3: With bit 5 = 0 (internal source) and bit 3 = 1 (prescaler to watchdog), the counter advances by one on each cycle in which the instruction-cycle enable is high.
- R4: With bit 5 = 1 and bit 4 = 0, each low-to-high change of the external pin advances the counter once. The new value is visible three clock edges after the pin changes, and high-to-low changes do not advance it.
- R5: With bit 5 = 1 and bit 4 = 1, only high-to-low changes of the pin advance the counter, with the same three-edge latency.
- R6: With bit 3 = 0, rate code n in bits 2:0 makes the counter advance once per 2^(n+1) source events (1:2 up to 1:256).
- R7: With bit 3 = 1, the watchdog event output pulses once per 2^n watchdog ticks (1:1 up to 1:128), one clock after the qualifying tick. The timer meanwhile counts every source event.
- R8: With bit 3 = 0, the watchdog event output pulses one clock after every watchdog tick.
- R9: An advance from FFh sets the counter to 00h and raises the overflow pulse for exactly one cycle, on the same edge.
- R10: The overflow flag is set by an overflow and holds until the clear input is asserted. An overflow in the same cycle as a clear leaves the flag set.
- R11: A counter write loads the written value, discards any advance in that cycle, and resets the prescaler count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_wr | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option register write data |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| icyc_tick | input | 1 | Instruction-cycle enable (internal source) |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Watchdog time-base tick |
| ovf_clr | input | 1 | Clear for the sticky overflow flag |
| opt_q | output | 8 | Current option register |
| cnt_q | output | 8 | Current counter value |
| ovf_pulse | output | 1 | One-cycle wrap indication |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_event | output | 1 | Watchdog tick after optional postscaling |
| pullup_dis | output | 1 | Stored pull-up disable bit |
| int_rise | output | 1 | Stored interrupt-edge select bit |

## Verification
A wrong prescaler count or a wrong tap has no immediate effect on the counter. It shows up as the counter reaching its value early or late over a run of 2^(n+1) events, so the divide checks count a whole period and also sample one event short of it. A stale synchroniser history would produce a spurious or missing advance within three edges of a pin change or of an edge-select change. An overflow flag that is wrong shows at the first wrap, or at the first clear that follows it.

// File: rtl/event_timer8_pkg.sv
package event_timer8_pkg;

    localparam int OPT_W = 8;

    // Option register layout, most significant bit first
    typedef struct packed {
        logic       pu_dis;    // 1: pull-ups off
        logic       irq_rise;  // 1: interrupt on rising edge
        logic       src_ext;   // 1: count pin edges
        logic       src_fall;  // 1: count falling pin edges
        logic       psc_wdt;   // 1: prescaler serves the watchdog
        logic [2:0] rate;      // prescaler rate code
    } opt_t;

    localparam opt_t OPT_RESET = '1;

endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic synced, prev;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], pin};
        synced     = st_q.chain[STAGES-1];
        prev       = st_q.chain[STAGES];
        evt        = fall_sel ? (prev & ~synced) : (synced & ~prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/shared_prescaler.sv
module shared_prescaler #(
    parameter int PSC_W = 8,
    parameter int SEL_W = $clog2(PSC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic             to_wdt,
    input  logic [SEL_W-1:0] rate,
    output logic             pulse
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic [SEL_W:0]   shamt;
    logic [PSC_W:0]   mask_w;
    logic [PSC_W-1:0] mask;

    always_comb begin
        // timer use divides by 2^(n+1), watchdog use by 2^n
        shamt  = to_wdt ? {1'b0, rate} : ({1'b0, rate} + 1'b1);
        mask_w = ((PSC_W+1)'(1) << shamt) - (PSC_W+1)'(1);
        mask   = mask_w[PSC_W-1:0];
        pulse  = evt && ((st_q.cnt & mask) == mask);

        st_d = st_q;
        if (clr)      st_d.cnt = '0;
        else if (evt) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/count_core.sv
module count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
        logic             flag;
    } core_state_t;

    core_state_t st_d, st_q;
    logic hit;

    always_comb begin
        hit  = inc && !load && (st_q.cnt == CNT_MAX);
        st_d = st_q;
        if (load)     st_d.cnt = load_val;
        else if (inc) st_d.cnt = st_q.cnt + 1'b1;
        st_d.wrap = hit;
        if (hit)           st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign wrap = st_q.wrap;
    assign flag = st_q.flag;
endmodule

// File: rtl/event_timer8.sv
module event_timer8
    import event_timer8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opt_wr,
    input  logic [OPT_W-1:0] opt_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             icyc_tick,
    input  logic             ext_pin,
    input  logic             wdt_tick,
    input  logic             ovf_clr,
    output logic [OPT_W-1:0] opt_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_pulse,
    output logic             ovf_flag,
    output logic             wdt_event,
    output logic             pullup_dis,
    output logic             int_rise
);
    localparam int SEL_W = $clog2(PSC_W);

    typedef struct packed {
        opt_t opt;
        logic wdt_evt;
    } top_state_t;

    top_state_t st_d, st_q;
    logic ext_evt, src_evt, psc_in, psc_out, cnt_inc;

    pin_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .fall_sel (st_q.opt.src_fall),
        .evt      (ext_evt)
    );

    shared_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_wr),
        .evt    (psc_in),
        .to_wdt (st_q.opt.psc_wdt),
        .rate   (st_q.opt.rate[SEL_W-1:0]),
        .pulse  (psc_out)
    );

    count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .inc      (cnt_inc),
        .flag_clr (ovf_clr),
        .cnt      (cnt_q),
        .wrap     (ovf_pulse),
        .flag     (ovf_flag)
    );

    always_comb begin
        src_evt = st_q.opt.src_ext ? ext_evt : icyc_tick;
        psc_in  = st_q.opt.psc_wdt ? wdt_tick : src_evt;
        cnt_inc = st_q.opt.psc_wdt ? src_evt : psc_out;

        st_d         = st_q;
        st_d.wdt_evt = st_q.opt.psc_wdt ? psc_out : wdt_tick;
        if (opt_wr) st_d.opt = opt_t'(opt_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.opt     <= OPT_RESET;
            st_q.wdt_evt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign opt_q      = st_q.opt;
    assign wdt_event  = st_q.wdt_evt;
    assign pullup_dis = st_q.opt.pu_dis;
    assign int_rise   = st_q.opt.irq_rise;
endmodule

// File: rtl/event_timer8_chk.sv
module event_timer8_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             opt_wr,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             wdt_tick,
    input logic             ovf_clr,
    input logic [7:0]       opt_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_pulse,
    input logic             ovf_flag,
    input logic             wdt_event
);
    AST_OPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_wr |=> $stable(opt_q));  // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));  // R3
    AST_WDT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_q[3] && !wdt_tick && !opt_wr) |=> !wdt_event);  // R7
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (cnt_q == '0));  // R9
    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);  // R9
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ovf_flag);  // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);  // R10
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(cnt_wdata)));  // R11
endmodule

bind event_timer8 event_timer8_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opt_wr    (opt_wr),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .wdt_tick  (wdt_tick),
    .ovf_clr   (ovf_clr),
    .opt_q     (opt_q),
    .cnt_q     (cnt_q),
    .ovf_pulse (ovf_pulse),
    .ovf_flag  (ovf_flag),
    .wdt_event (wdt_event)
);

// File: tb/event_timer8_tb.sv
module event_timer8_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_wr = 1'b0, cnt_wr = 1'b0;
    logic [7:0] opt_wdata = '0, cnt_wdata = '0;
    logic       icyc_tick = 1'b0, ext_pin = 1'b0, wdt_tick = 1'b0, ovf_clr = 1'b0;
    logic [7:0] opt_q, cnt_q;
    logic       ovf_pulse, ovf_flag, wdt_event, pullup_dis, int_rise;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    event_timer8 u_dut (
        .clk(clk), .rst_n(rst_n), .opt_wr(opt_wr), .opt_wdata(opt_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .icyc_tick(icyc_tick),
        .ext_pin(ext_pin), .wdt_tick(wdt_tick), .ovf_clr(ovf_clr),
        .opt_q(opt_q), .cnt_q(cnt_q), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag),
        .wdt_event(wdt_event), .pullup_dis(pullup_dis), .int_rise(int_rise)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_opt(input logic [7:0] v);
        opt_wr = 1'b1; opt_wdata = v; step(1); opt_wr = 1'b0;
    endtask

    task automatic put_cnt(input logic [7:0] v);
        cnt_wr = 1'b1; cnt_wdata = v; step(1); cnt_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 opt", opt_q, 8'hFF);
        check("R1 cnt", cnt_q, 8'h00);
        check("R1 flags", {ovf_flag, ovf_pulse, wdt_event}, 3'b000);
        check("R1 side bits", {pullup_dis, int_rise}, 2'b11);
    endtask

    task automatic t_option;
        put_opt(8'h3F);
        check("R2 opt", opt_q, 8'h3F);
        check("R2 side bits", {pullup_dis, int_rise}, 2'b00);
        put_opt(8'h80);
        check("R2 side bits 2", {pullup_dis, int_rise}, 2'b10);
        step(3);
        check("R2 hold", opt_q, 8'h80);
    endtask

    task automatic t_internal;
        put_opt(8'h08);
        put_cnt(8'h00);
        icyc_tick = 1'b1; step(5); icyc_tick = 1'b0;
        check("R3 run of 5", cnt_q, 8'd5);
        for (int i = 0; i < 6; i++) begin
            icyc_tick = (i % 2 == 0); step(1);
        end
        icyc_tick = 1'b0;
        check("R3 alternating", cnt_q, 8'd8);
    endtask

    task automatic t_ext_rise;
        put_opt(8'h28);
        put_cnt(8'h00);
        ext_pin = 1'b1; step(2);
        check("R4 latency before", cnt_q, 8'd0);
        step(1);
        check("R4 latency after", cnt_q, 8'd1);
        ext_pin = 1'b0; step(4);
        check("R4 falling ignored", cnt_q, 8'd1);
        for (int i = 0; i < 2; i++) begin
            ext_pin = 1'b1; step(4); ext_pin = 1'b0; step(4);
        end
        check("R4 pulses", cnt_q, 8'd3);
    endtask

    task automatic t_ext_fall;
        put_opt(8'h38);
        put_cnt(8'h00);
        ext_pin = 1'b1; step(4);
        check("R5 rising ignored", cnt_q, 8'd0);
        ext_pin = 1'b0; step(2);
        check("R5 latency before", cnt_q, 8'd0);
        step(1);
        check("R5 latency after", cnt_q, 8'd1);
    endtask

    task automatic t_prescale;
        put_opt(8'h01);
        put_cnt(8'h00);
        icyc_tick = 1'b1; step(12); icyc_tick = 1'b0;
        check("R6 rate1 div4", cnt_q, 8'd3);
        put_opt(8'h00);
        put_cnt(8'h00);
        icyc_tick = 1'b1; step(10); icyc_tick = 1'b0;
        check("R6 rate0 div2", cnt_q, 8'd5);
        put_opt(8'h07);
        put_cnt(8'h00);
        icyc_tick = 1'b1; step(255);
        check("R6 rate7 short", cnt_q, 8'd0);
        step(1); icyc_tick = 1'b0;
        check("R6 rate7 div256", cnt_q, 8'd1);
    endtask

    task automatic t_load_clears;
        put_opt(8'h01);
        put_cnt(8'h00);
        icyc_tick = 1'b1; step(3); icyc_tick = 1'b0;
        put_cnt(8'h10);
        check("R11 load", cnt_q, 8'h10);
        icyc_tick = 1'b1; step(3);
        check("R11 prescaler cleared", cnt_q, 8'h10);
        step(1); icyc_tick = 1'b0;
        check("R11 after full period", cnt_q, 8'h11);
        put_opt(8'h08);
        icyc_tick = 1'b1; put_cnt(8'h40); icyc_tick = 1'b0;
        check("R11 write beats advance", cnt_q, 8'h40);
    endtask

    task automatic t_watchdog;
        int seen;
        put_opt(8'h0A);
        put_cnt(8'h00);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            wdt_tick = 1'b1; icyc_tick = 1'b1; step(1);
            if (wdt_event) seen++;
        end
        wdt_tick = 1'b0; icyc_tick = 1'b0;
        check("R7 wdt div4 events", seen, 2);
        check("R7 timer undivided", cnt_q, 8'd8);
        put_opt(8'h01);
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            wdt_tick = 1'b1; step(1);
            if (wdt_event) seen++;
        end
        wdt_tick = 1'b0; step(1);
        check("R8 wdt undivided", seen, 5);
        check("R8 wdt idle", wdt_event, 1'b0);
    endtask

    task automatic t_overflow;
        put_opt(8'h08);
        put_cnt(8'hFE);
        icyc_tick = 1'b1; step(1);
        check("R9 at FF", {cnt_q, ovf_pulse}, {8'hFF, 1'b0});
        step(1); icyc_tick = 1'b0;
        check("R9 wrap", {cnt_q, ovf_pulse, ovf_flag}, {8'h00, 1'b1, 1'b1});
        step(1);
        check("R9 pulse one cycle", ovf_pulse, 1'b0);
        check("R10 sticky", ovf_flag, 1'b1);
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
        check("R10 cleared", ovf_flag, 1'b0);
        put_cnt(8'hFF);
        icyc_tick = 1'b1; ovf_clr = 1'b1; step(1);
        icyc_tick = 1'b0; ovf_clr = 1'b0;
        check("R10 set wins over clear", ovf_flag, 1'b1);
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_option();
        t_internal();
        t_ext_rise();
        t_ext_fall();
        t_prescale();
        t_load_clears();
        t_watchdog();
        t_overflow();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule